// File: doc/BRIEF.md
# ACPI Sleep-State Rail Sequencer

This block is the digital control core of a multi-rail motherboard power controller. Two active-low sleep request lines come from the system chipset. The block filters short glitches out of them and decodes the request into the active state, the S3 (suspend-to-RAM) state or the S4/S5 (soft-off) state. It does not allow a move straight from one sleep state to the other. From that state it drives the enables for the pass devices of each rail. It also takes a memory-voltage selection, a 5VDUAL sleep-support option, standby-bias, shutdown, undervoltage and overtemperature flags, and it produces one latched fault output.

The analog side of the controller sits outside this block: regulation loops, soft-start ramps and comparators. Every comparator result reaches the block as a clean, synchronous digital flag. The tracked state is brought out on `pwr_state`, so that the sequencing can be observed directly.

Top module: `acpi_rail_sequencer`

## Requirements
- R1: A level change on `slp3_n` or `slp5_n` is accepted only after it has been seen on `GLITCH_CYC` consecutive rising clock edges. A shorter pulse leaves the state unchanged. The state moves one edge after the filtered value flips.
- R2: `pwr_state` encodes 00 = waiting/off, 01 = active, 10 = S3, 11 = S4/S5. The filtered request decodes as follows: `slp5_n` low (with `slp3_n` at either level) means S4/S5; only `slp3_n` low means S3; both high means active. Both filtered values reset low. From waiting, the block moves to the decoded request only once each raw input equals its filtered value. So after reset the block enters active only when both inputs are filtered high.
- R3: A request for S4/S5 while in S3, or for S3 while in S4/S5, is ignored. The block leaves a sleep state only for active.
- R4: The latched 5VDUAL sleep-support bit samples `dual5_sleep_en` on entry into a sleep state, on the rise of `bias_ok` and on the fall of `shut_req`. Changes at any other time are ignored.
- R5: `dual33_en` is high in every state while `bias_ok` is high, with no shutdown and no fault. It is low when `bias_ok` is low, and then the block returns to waiting.
- R6: `act_gate` and `clk25_en` are high only in active. `dual33_sleep_drv` is high only in S3 or S4/S5.
- R7: `dual5_sleep_drv` is high in S3 or S4/S5 only when the latched sleep-support bit is 1.
- R8: `mem_sel` = 00 enables only the 2.5 V memory drives. `mem_sel` = 11 enables only the 3.3 V memory sleep drive. 01 or 10 enables both. `mem25_act_drv` follows active, while `mem25_sleep_drv` and `mem33_sleep_drv` follow sleep.
- R9: While `shut_req` is high, every enable output and `fault` are low, and one edge later the state is waiting.
- R10: Any set bit of `uv_flag`, or `ot_flag`, sets a fault latch at the next edge. `fault` then stays high and all rail enables stay low until `shut_req` or a low `bias_ok` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Standby bias present (low = power-on reset) |
| shut_req | input | 1 | Shutdown request |
| slp3_n | input | 1 | Active-low S3 request |
| slp5_n | input | 1 | Active-low S4/S5 request |
| dual5_sleep_en | input | 1 | 5VDUAL sleep-support option |
| mem_sel | input | 2 | Memory-voltage select |
| uv_flag | input | UV_N | Undervoltage flags, one per monitored supply |
| ot_flag | input | 1 | Overtemperature flag |
| pwr_state | output | 2 | Tracked power state |
| act_gate | output | 1 | Shared gate drive for active-state switches |
| dual33_en | output | 1 | 3.3VDUAL rail enable |
| dual33_sleep_drv | output | 1 | 3.3VDUAL sleep pass drive |
| dual5_sleep_drv | output | 1 | 5VDUAL standby switch drive |
| mem25_act_drv | output | 1 | 2.5 V memory active pass drive |
| mem25_sleep_drv | output | 1 | 2.5 V memory sleep pass drive |
| mem33_sleep_drv | output | 1 | 3.3 V memory sleep pass drive |
| clk25_en | output | 1 | Clock-supply rail enable |
| fault | output | 1 | Latched fault indication |

## Verification
A sleep input that changes settles `pwr_state` and the rail drives on the (`GLITCH_CYC`+1)-th rising edge after the change. The bench therefore samples once after `GLITCH_CYC` edges, where the old state must still hold, and once after the next edge. Fault flags, shutdown, bias loss and bias return each act at the first edge. `mem_sel` acts without any edge. All of these are sampled on the falling edge that follows the due edge. Inputs also change only on falling edges, so that each count starts from a known edge.

// File: rtl/acpi_rail_sequencer.sv
module acpi_rail_sequencer #(
  parameter int GLITCH_CYC = 500,
  parameter int UV_N       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bias_ok,
  input  logic            shut_req,
  input  logic            slp3_n,
  input  logic            slp5_n,
  input  logic            dual5_sleep_en,
  input  logic [1:0]      mem_sel,
  input  logic [UV_N-1:0] uv_flag,
  input  logic            ot_flag,
  output logic [1:0]      pwr_state,
  output logic            act_gate,
  output logic            dual33_en,
  output logic            dual33_sleep_drv,
  output logic            dual5_sleep_drv,
  output logic            mem25_act_drv,
  output logic            mem25_sleep_drv,
  output logic            mem33_sleep_drv,
  output logic            clk25_en,
  output logic            fault
);

  localparam int CW = $clog2(GLITCH_CYC + 1);

  typedef enum logic [1:0] {ST_OFF = 2'b00, ST_ACT = 2'b01, ST_S3 = 2'b10, ST_S45 = 2'b11} st_t;

  logic [1:0] raw, filt;
  assign raw = {slp5_n, slp3_n};

  for (genvar i = 0; i < 2; i++) begin : g_flt
    logic [CW-1:0] cnt;
    logic          f;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (raw[i] == f) begin
        cnt <= '0;
      end else if (cnt == CW'(GLITCH_CYC - 1)) begin
        f   <= raw[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    assign filt[i] = f;
  end

  st_t st, nxt, req;
  logic settled, sleeping, enter_slp;
  logic en5_q, fault_q, bias_d, shut_d, ok;

  assign req      = !filt[1] ? ST_S45 : (!filt[0] ? ST_S3 : ST_ACT);
  assign settled  = (raw == filt);
  assign sleeping = (st == ST_S3) || (st == ST_S45);

  always_comb begin
    nxt = st;
    if (!bias_ok || shut_req) nxt = ST_OFF;
    else begin
      case (st)
        ST_OFF:  if (settled) nxt = req;
        ST_ACT:  nxt = req;
        default: if (req == ST_ACT) nxt = ST_ACT;
      endcase
    end
  end

  assign enter_slp = ((nxt == ST_S3) || (nxt == ST_S45)) && !sleeping;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_OFF;
      en5_q   <= 1'b1;
      fault_q <= 1'b0;
      bias_d  <= 1'b0;
      shut_d  <= 1'b0;
    end else begin
      st     <= nxt;
      bias_d <= bias_ok;
      shut_d <= shut_req;
      if (enter_slp || (bias_ok && !bias_d) || (!shut_req && shut_d))
        en5_q <= dual5_sleep_en;
      if (!bias_ok || shut_req)             fault_q <= 1'b0;
      else if ((|uv_flag) || ot_flag)       fault_q <= 1'b1;
    end

  assign ok = bias_ok && !shut_req && !fault_q;

  assign pwr_state        = st;
  assign act_gate         = ok && (st == ST_ACT);
  assign clk25_en         = ok && (st == ST_ACT);
  assign dual33_en        = ok;
  assign dual33_sleep_drv = ok && sleeping;
  assign dual5_sleep_drv  = ok && sleeping && en5_q;
  assign mem25_act_drv    = ok && (st == ST_ACT) && (mem_sel != 2'b11);
  assign mem25_sleep_drv  = ok && sleeping && (mem_sel != 2'b11);
  assign mem33_sleep_drv  = ok && sleeping && (mem_sel != 2'b00);
  assign fault            = fault_q && bias_ok && !shut_req;

  p_filter_follows_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt[0]) |-> (filt[0] == $past(raw[0])));

  p_no_s3_to_s45_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_S3) |=> (st != ST_S45));

  p_no_s45_to_s3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_S45) |=> (st != ST_S3));

  p_en5_held_in_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && bias_ok && !shut_req) |=> (!sleeping || $stable(en5_q)));

  p_shut_to_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> (st == ST_OFF));

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && bias_ok && !shut_req) |=> fault_q);

endmodule

// File: tb/acpi_rail_sequencer_tb_top.sv
`timescale 1ns/1ps
module acpi_rail_sequencer_tb_top;
  localparam int GC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_ok = 1'b1, shut_req = 1'b0, slp3_n = 1'b1, slp5_n = 1'b1;
  logic dual5_sleep_en = 1'b1, ot_flag = 1'b0;
  logic [1:0] mem_sel = 2'b01;
  logic [4:0] uv_flag = '0;
  logic [1:0] pwr_state;
  logic act_gate, dual33_en, dual33_sleep_drv, dual5_sleep_drv;
  logic mem25_act_drv, mem25_sleep_drv, mem33_sleep_drv, clk25_en, fault;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acpi_rail_sequencer #(.GLITCH_CYC(GC), .UV_N(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .shut_req(shut_req),
    .slp3_n(slp3_n), .slp5_n(slp5_n), .dual5_sleep_en(dual5_sleep_en),
    .mem_sel(mem_sel), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .pwr_state(pwr_state), .act_gate(act_gate), .dual33_en(dual33_en),
    .dual33_sleep_drv(dual33_sleep_drv), .dual5_sleep_drv(dual5_sleep_drv),
    .mem25_act_drv(mem25_act_drv), .mem25_sleep_drv(mem25_sleep_drv),
    .mem33_sleep_drv(mem33_sleep_drv), .clk25_en(clk25_en), .fault(fault));

  // [10:9] state, 8 act_gate, 7 dual33_en, 6 dual33_sleep, 5 dual5_sleep,
  // 4 mem25_act, 3 mem25_sleep, 2 mem33_sleep, 1 clk25_en, 0 fault
  logic [10:0] obs;
  assign obs = {pwr_state, act_gate, dual33_en, dual33_sleep_drv, dual5_sleep_drv,
                mem25_act_drv, mem25_sleep_drv, mem33_sleep_drv, clk25_en, fault};

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [10:0] exp);
    total++;
    if (obs !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, obs, exp);
    end
  endtask

  task automatic t_reset_startup;
    wait_n(3);
    chk("R5 reset waiting, dual33 on", 11'h080);
    rst_n = 1'b1;
    wait_n(GC);
    chk("R2 still waiting before filter settles", 11'h080);
    wait_n(1);
    chk("R2 active after both filtered high", 11'h392);
  endtask

  task automatic t_glitch;
    slp3_n = 1'b0;
    wait_n(GC - 1);
    slp3_n = 1'b1;
    wait_n(GC + 2);
    chk("R1 short pulse ignored", 11'h392);
  endtask

  task automatic t_enter_s3;
    slp3_n = 1'b0;
    wait_n(GC);
    chk("R1 active holds until filter edge", 11'h392);
    wait_n(1);
    chk("R6 R7 S3 entered with sleep drives", 11'h4EC);
  endtask

  task automatic t_illegal;
    slp5_n = 1'b0;
    wait_n(GC + 4);
    chk("R3 S3 ignores S4/S5 request", 11'h4EC);
    slp3_n = 1'b1;
    wait_n(GC + 4);
    chk("R3 S3 ignores S5-only request", 11'h4EC);
    slp5_n = 1'b1;
    wait_n(GC + 4);
    chk("R2 S3 back to active", 11'h392);
  endtask

  task automatic t_s45_en5;
    dual5_sleep_en = 1'b0;
    slp5_n = 1'b0;
    wait_n(GC + 4);
    chk("R7 S4/S5 with sleep support off", 11'h6CC);
    dual5_sleep_en = 1'b1;
    wait_n(5);
    chk("R4 option change in sleep ignored", 11'h6CC);
    slp5_n = 1'b1;
    slp3_n = 1'b0;
    wait_n(GC + 4);
    chk("R3 S4/S5 ignores S3 request", 11'h6CC);
    slp3_n = 1'b1;
    wait_n(GC + 4);
    chk("R2 S4/S5 back to active", 11'h392);
  endtask

  task automatic t_mem;
    mem_sel = 2'b00;
    wait_n(1);
    chk("R8 code 00 active", 11'h392);
    mem_sel = 2'b11;
    wait_n(1);
    chk("R8 code 11 active", 11'h382);
    slp3_n = 1'b0;
    wait_n(GC + 1);
    chk("R8 code 11 in S3", 11'h4E4);
    mem_sel = 2'b00;
    wait_n(1);
    chk("R8 code 00 in S3", 11'h4E8);
    mem_sel = 2'b10;
    wait_n(1);
    chk("R8 code 10 in S3", 11'h4EC);
  endtask

  task automatic t_shut_relatch;
    dual5_sleep_en = 1'b0;
    wait_n(3);
    chk("R4 option held in S3", 11'h4EC);
    shut_req = 1'b1;
    wait_n(1);
    chk("R9 shutdown clears all", 11'h000);
    wait_n(3);
    chk("R9 shutdown holds all off", 11'h000);
    shut_req = 1'b0;
    wait_n(1);
    chk("R4 relatch on shutdown exit", 11'h4CC);
    dual5_sleep_en = 1'b1;
    slp3_n = 1'b1;
    wait_n(GC + 4);
    chk("R2 active after shutdown cycle", 11'h392);
  endtask

  task automatic t_fault;
    uv_flag = 5'b00100;
    chk("R10 no fault before edge", 11'h392);
    wait_n(1);
    chk("R10 undervoltage fault", 11'h201);
    uv_flag = '0;
    wait_n(5);
    chk("R10 fault sticky", 11'h201);
    shut_req = 1'b1;
    wait_n(1);
    chk("R9 shutdown masks fault", 11'h000);
    shut_req = 1'b0;
    wait_n(1);
    chk("R10 fault cleared by shutdown", 11'h392);
    ot_flag = 1'b1;
    wait_n(1);
    chk("R10 overtemperature fault", 11'h201);
    ot_flag = 1'b0;
    bias_ok = 1'b0;
    wait_n(1);
    chk("R5 bias loss all off", 11'h000);
    bias_ok = 1'b1;
    wait_n(1);
    chk("R10 fault cleared by bias return", 11'h392);
  endtask

  initial begin
    t_reset_startup();
    t_glitch();
    t_enter_s3();
    t_illegal();
    t_s45_en5();
    t_mem();
    t_shut_relatch();
    t_fault();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule